// File: doc/BRIEF.md
# JTAG Host Scan Engine

This block acts as the master of a JTAG chain. It drives TCK, TMS and TDI and samples TDO. It takes one request holding a 4-bit instruction code and a data vector. From these it runs a full scan: it moves the target's TAP controller to Shift-IR, loads the instruction, moves on to Shift-DR, shifts the data register while capturing what the target sends back, and returns the TAP to Run-Test/Idle. The captured bits then go back to the requester.

The caller does not give the data-register length. The engine looks it up per instruction in a fixed table. The table includes two long page registers of 1024 and 1032 bits. TCK comes from the system clock through a divider that software sets. The result leaves through a valid/ready response port. New requests are refused until the caller takes that response. An instruction code that is not in the table gives an error and drives no TCK at all.

Top module: `jtag_scan_engine`

## Requirements
- R1: While rst_ni is low and right after it, tck_o, tms_o and tdi_o are 0, req_ready_o is 1, and rsp_valid_o, err_o and busy_o are 0.
- R2: TCK idles low between scans. During a scan each high phase of tck_o lasts exactly div_i+1 system clock cycles.
- R3: tms_o and tdi_o never change while tck_o is high. They move only on the edge where TCK falls.
- R4: One scan is exactly 18+N rising TCK edges, where N is the register length. The TMS order is: 0,0 (idle), then 1,1,0,0 to Shift-IR, then the IR bits, then 1,0,1,0,0 through Update-IR and Run-Test/Idle to Shift-DR, then the DR bits, then 1,0 back to Run-Test/Idle, then one more 0. The TAP ends in Run-Test/Idle.
- R5: The 4-bit instruction goes out on TDI least significant bit first. TMS is high only on its fourth (most significant) bit.
- R6: Register length N by instruction code: 0x1 gives 32, 0x4 gives 16, 0x5 gives 15, 0x6 gives 1024, 0x7 gives 1032, 0xC gives 1 and 0xF gives 1. rsp_len_o returns N.
- R7: Data bits 0..N-1 of req_data_i go out least significant bit first. TMS is high only on bit N-1. Bits at index N and above are never shifted.
- R8: TDO is sampled at the end of each high phase of TCK during Shift-DR. The k-th sample lands in rsp_data_o[k]. Bits N and above of rsp_data_o are 0.
- R9: While a scan runs or a response waits, req_ready_o is 0 and req_valid_i is ignored. rsp_valid_o and rsp_data_o hold until rsp_ready_i is seen. After that req_ready_o returns to 1.
- R10: A request with a code not in the R6 table sets err_o, produces no TCK edge and no response, and leaves req_ready_o at 1. The next accepted valid request clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W (8) | TCK half period minus one, in system cycles |
| req_valid_i | input | 1 | Scan request valid |
| req_ready_o | output | 1 | Engine idle and able to take a request |
| req_ir_i | input | 4 | Instruction code |
| req_data_i | input | DATA_W (1032) | Data to shift, bit 0 first |
| rsp_valid_o | output | 1 | Captured vector valid |
| rsp_ready_i | input | 1 | Consumer takes the captured vector |
| rsp_data_o | output | DATA_W (1032) | Captured TDO bits, bit 0 first |
| rsp_len_o | output | LEN_W (11) | Register length N of the finished scan |
| err_o | output | 1 | Last request had an unknown instruction code |
| busy_o | output | 1 | Scan running or response pending |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |

## Verification
The assertions check the pin discipline on every cycle. TMS and TDI must stay still during a TCK high phase. Every TCK rise must come from a divider tick. TCK must stay low while idle or in error. A pending response must hold until it is accepted. Other properties only show up once a TAP model is attached, so the bench scenarios cover them: the exact TMS walk, the order of the IR and DR bits, the per-instruction length, the alignment of captured TDO, and the fact that data above the register length never goes out. Long page scans, one-bit registers, unknown codes and requests sent while busy are each exercised against that model.

// File: rtl/jtag_scan_pkg.sv
package jtag_scan_pkg;
  localparam int unsigned IR_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_TO_IR, PH_IR, PH_TO_DR, PH_DR, PH_POST, PH_RESP
  } phase_e;

  // 0 marks an unknown code
  function automatic int unsigned dr_len(logic [IR_W-1:0] code);
    case (code)
      4'h1:    return 32;
      4'h4:    return 16;
      4'h5:    return 15;
      4'h6:    return 1024;
      4'h7:    return 1032;
      4'hC:    return 1;
      4'hF:    return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/jtag_len_lut.sv
module jtag_len_lut
  import jtag_scan_pkg::*;
#(
  parameter int unsigned DATA_W = 1032,
  parameter int unsigned LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic [IR_W-1:0]  code_i,
  output logic             hit_o,
  output logic [LEN_W-1:0] len_o
);
  int unsigned raw;

  always_comb begin
    raw   = dr_len(code_i);
    hit_o = (raw != 0) && (raw <= DATA_W);  // entries wider than the port are refused
    len_o = hit_o ? LEN_W'(raw) : '0;
  end

  always_comb begin
    if (hit_o) a_len_bound_r6 : assert (len_o != '0 && 32'(len_o) <= DATA_W);
  end
endmodule

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end

  p_tick_needs_run_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> run_i);
endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine
  import jtag_scan_pkg::*;
#(
  parameter int unsigned DATA_W = 1032,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [IR_W-1:0]   req_ir_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [LEN_W-1:0]  rsp_len_o,
  output logic              err_o,
  output logic              busy_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i
);
  localparam int unsigned IR_IW = $clog2(IR_W);

  phase_e            ph_q;
  logic [LEN_W-1:0]  cnt_q, len_q, last_cnt;
  logic [IR_W-1:0]   ir_q;
  logic [DATA_W-1:0] sr_q, ld_mask;
  logic              tck_q, err_q, running, tick, lut_hit, cnt_last;
  logic [LEN_W-1:0]  lut_len;
  phase_e            ph_next;

  jtag_len_lut #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_lut (
    .code_i(req_ir_i), .hit_o(lut_hit), .len_o(lut_len)
  );

  assign running = (ph_q != PH_IDLE) && (ph_q != PH_RESP);

  jtag_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(running), .div_i(div_i), .tick_o(tick)
  );

  // zero-pad beyond the register length at load time
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign ld_mask[i] = (32'(i) < 32'(lut_len));
  end

  always_comb begin
    last_cnt = '0;
    ph_next  = PH_IDLE;
    case (ph_q)
      PH_PRE:   begin last_cnt = LEN_W'(1);     ph_next = PH_TO_IR; end
      PH_TO_IR: begin last_cnt = LEN_W'(3);     ph_next = PH_IR;    end
      PH_IR:    begin last_cnt = LEN_W'(IR_W-1); ph_next = PH_TO_DR; end
      PH_TO_DR: begin last_cnt = LEN_W'(4);     ph_next = PH_DR;    end
      PH_DR:    begin last_cnt = len_q - LEN_W'(1); ph_next = PH_POST; end
      PH_POST:  begin last_cnt = LEN_W'(2);     ph_next = PH_RESP;  end
      default:  ;
    endcase
  end
  assign cnt_last = (cnt_q == last_cnt);

  always_comb begin
    tms_o = 1'b0;
    tdi_o = 1'b0;
    case (ph_q)
      PH_TO_IR: tms_o = (cnt_q < LEN_W'(2));                     // 1,1,0,0
      PH_IR:    begin tms_o = cnt_last; tdi_o = ir_q[cnt_q[IR_IW-1:0]]; end
      PH_TO_DR: tms_o = (cnt_q == '0) || (cnt_q == LEN_W'(2));   // 1,0,1,0,0
      PH_DR:    begin tms_o = cnt_last; tdi_o = sr_q[cnt_q]; end
      PH_POST:  tms_o = (cnt_q == '0);                           // 1,0,0
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      len_q <= '0;
      ir_q  <= '0;
      sr_q  <= '0;
      tck_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (req_valid_i) begin
          if (lut_hit) begin
            ph_q  <= PH_PRE;
            cnt_q <= '0;
            len_q <= lut_len;
            ir_q  <= req_ir_i;
            sr_q  <= req_data_i & ld_mask;
            err_q <= 1'b0;
          end else begin
            err_q <= 1'b1;
          end
        end
        PH_RESP: if (rsp_ready_i) ph_q <= PH_IDLE;
        default: if (tick) begin
          if (!tck_q) begin
            tck_q <= 1'b1;
          end else begin
            tck_q <= 1'b0;
            // end of high phase: target output settled after the rise
            if (ph_q == PH_DR) sr_q[cnt_q] <= tdo_i;
            if (cnt_last) begin
              cnt_q <= '0;
              ph_q  <= ph_next;
            end else begin
              cnt_q <= cnt_q + LEN_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign tck_o       = tck_q;
  assign req_ready_o = (ph_q == PH_IDLE);
  assign busy_o      = (ph_q != PH_IDLE);
  assign rsp_valid_o = (ph_q == PH_RESP);
  assign rsp_data_o  = sr_q;
  assign rsp_len_o   = len_q;
  assign err_o       = err_q;

  p_pins_hold_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_o && $past(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o)));

  p_rise_on_tick_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tck_o) |-> $past(tick));

  p_idle_low_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !tck_o);

  p_rsp_hold_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  p_err_quiet_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!tck_o && !rsp_valid_o));
endmodule

// File: tb/jtag_scan_engine_tb_top.sv
module jtag_scan_engine_tb_top;
  localparam int DW = 1032;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    div_r = '0;
  logic          req_valid = 1'b0, rsp_ready = 1'b0;
  logic [3:0]    req_ir = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_ready, rsp_valid, err, busy, tck, tms, tdi;
  logic [DW-1:0] rsp_data;
  logic [10:0]   rsp_len;
  logic          tdo = 1'b0;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  jtag_scan_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_r),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_ir_i(req_ir), .req_data_i(req_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data), .rsp_len_o(rsp_len),
    .err_o(err), .busy_o(busy), .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .tdo_i(tdo)
  );

  function automatic int exp_len(logic [3:0] c);
    case (c)
      4'h1: return 32;  4'h4: return 16;  4'h5: return 15;
      4'h6: return 1024; 4'h7: return 1032; 4'hC: return 1; 4'hF: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [DW-1:0] len_mask(int n);
    logic [DW-1:0] m = '0;
    for (int i = 0; i < DW; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [DW-1:0] rnd_vec();
    logic [DW-1:0] v = '0;
    for (int i = 0; i < DW; i += 32) v = (v << 32) | DW'($urandom);
    return v;
  endfunction

  // ---------------- target TAP model ----------------
  typedef enum logic [3:0] {TLR, RTI, SDS, CDR, SHDR, E1DR, PDR, E2DR, UDR,
                            SIS, CIR, SHIR, E1IR, PIR, E2IR, UIR} tap_e;

  function automatic tap_e tap_next(tap_e s, logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDS  : RTI;
      SDS:  return m ? SIS  : CDR;
      CDR:  return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SHDR;
      UDR:  return m ? SDS  : RTI;
      SIS:  return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SHIR;
      default: return m ? SDS : RTI;
    endcase
  endfunction

  tap_e          tap = TLR;
  logic [3:0]    ir_sr = '0, ir_reg = '0;
  logic [DW-1:0] dr = '0, tgt_cap = '0;
  int            rises = 0;

  always @(posedge tck) begin
    automatic logic [DW-1:0] t;
    automatic int n = exp_len(ir_reg);
    case (tap)
      CIR:  ir_sr <= 4'b0001;
      SHIR: ir_sr <= {tdi, ir_sr[3:1]};
      UIR:  ir_reg <= ir_sr;
      CDR:  dr <= tgt_cap & len_mask(n);
      SHDR: begin t = dr >> 1; if (n > 0) t[n-1] = tdi; dr <= t; end
      default: ;
    endcase
    tap   <= tap_next(tap, tms);
    rises <= rises + 1;
  end

  always @(negedge tck)
    tdo <= (tap == SHDR) ? dr[0] : ((tap == SHIR) ? ir_sr[0] : 1'b0);

  // ---------------- pin monitors ----------------
  int   hi_run = 0, bad_hi = 0, bad_pin = 0;
  logic p_tck = 1'b0, p_tms = 1'b0, p_tdi = 1'b0;
  always @(negedge clk) begin
    if (tck) hi_run <= hi_run + 1;
    else if (hi_run != 0) begin
      if (hi_run != int'(div_r) + 1) bad_hi <= bad_hi + 1;
      hi_run <= 0;
    end
    if (rst_n && tck && p_tck && (tms != p_tms || tdi != p_tdi)) bad_pin <= bad_pin + 1;
    p_tck <= tck; p_tms <= tms; p_tdi <= tdi;
  end

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_scan(logic [3:0] ir, logic [DW-1:0] data, logic [7:0] dv, int hold, bit poke);
    int n = exp_len(ir);
    int r0, h0, p0, ready_bad = 0, hold_bad = 0;
    logic [DW-1:0] cap = rnd_vec();
    logic [DW-1:0] d0;
    tgt_cap = cap;
    div_r   = dv;
    @(negedge clk);
    r0 = rises; h0 = bad_hi; p0 = bad_pin;
    req_valid = 1'b1; req_ir = ir; req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    check(err == 1'b0, "R10", "err cleared by valid request", DW'(err), '0);
    if (poke) begin
      req_valid = 1'b1; req_ir = 4'h7; req_data = ~data;
      repeat (3) begin
        if (req_ready) ready_bad++;
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    while (!rsp_valid) begin
      if (req_ready) ready_bad++;
      @(negedge clk);
    end
    d0 = rsp_data;
    repeat (hold) begin
      @(negedge clk);
      if (!rsp_valid || rsp_data != d0 || req_ready) hold_bad++;
    end
    check(ready_bad == 0, "R9", "req_ready low while busy", DW'(ready_bad), '0);
    check(hold_bad == 0, "R9", "response held until ready", DW'(hold_bad), '0);
    check(rsp_len == 11'(n), "R6", "length lookup", DW'(rsp_len), DW'(n));
    check(rsp_data == (cap & len_mask(n)), "R8", "captured TDO vector", rsp_data, cap & len_mask(n));
    check(ir_reg == ir, "R5", "instruction at target", DW'(ir_reg), DW'(ir));
    check(dr == (data & len_mask(n)), "R7", "data at target", dr, data & len_mask(n));
    check(rises - r0 == 18 + n, "R4", "TCK rise count", DW'(rises - r0), DW'(18 + n));
    check(tap == RTI, "R4", "TAP parked in Run-Test/Idle", DW'(tap), DW'(RTI));
    check(bad_hi == h0, "R2", "TCK high phase length", DW'(bad_hi - h0), '0);
    check(bad_pin == p0, "R3", "TMS/TDI stable while TCK high", DW'(bad_pin - p0), '0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9", "ready after accept",
          DW'({rsp_valid, req_ready}), DW'(2'b01));
  endtask

  task automatic bad_scan(logic [3:0] ir);
    int r0, bad = 0;
    @(negedge clk);
    r0 = rises;
    req_valid = 1'b1; req_ir = ir; req_data = rnd_vec();
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) begin
      if (rsp_valid || !req_ready || tck) bad++;
      @(negedge clk);
    end
    check(err == 1'b1, "R10", "error flag on unknown code", DW'(err), DW'(1));
    check(bad == 0 && rises == r0, "R10", "no scan on unknown code", DW'(bad + rises - r0), '0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(!tck && !tms && !tdi && req_ready && !rsp_valid && !err && !busy, "R1", "outputs in reset",
          DW'({tck, tms, tdi, req_ready, rsp_valid, err, busy}), DW'(7'b0001000));
    rst_n = 1'b1;
    @(negedge clk);
    check(!tck && !tms && !tdi && req_ready && !rsp_valid && !err && !busy, "R1", "outputs after reset",
          DW'({tck, tms, tdi, req_ready, rsp_valid, err, busy}), DW'(7'b0001000));

    // directed corners
    do_scan(4'h1, rnd_vec(), 8'd5, 3, 1'b0);
    do_scan(4'h6, rnd_vec(), 8'd0, 2, 1'b1);
    bad_scan(4'h3);
    do_scan(4'h7, rnd_vec(), 8'd0, 0, 1'b0);
    do_scan(4'hC, '1, 8'd0, 1, 1'b1);
    bad_scan(4'h0);
    do_scan(4'hF, rnd_vec(), 8'd2, 0, 1'b0);

    // random mix
    for (int k = 0; k < 14; k++) begin
      int sel = int'($urandom % 8);
      if (sel == 0) begin
        logic [3:0] badc [9] = '{4'h0, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB, 4'hD, 4'hE};
        bad_scan(badc[$urandom % 9]);
      end else begin
        logic [3:0] good [5] = '{4'h1, 4'h4, 4'h5, 4'hC, 4'hF};
        do_scan(good[$urandom % 5], rnd_vec(), 8'($urandom % 4), int'($urandom % 4), 1'($urandom % 2));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule